// File: doc/BRIEF.md
# UART Control and Modem Flow-Control Layer

This block is the control layer of a simple UART. One control word, written over a register port, holds a global enable, separate enables for transmit and receive, two modem-line bits (request-to-send and data-terminal-ready), and two automatic flow-control switches. Around that word sit a basic 8N1 transmitter, an 8N1 receiver and a four-entry receive FIFO. The modem outputs are active low, so setting a control bit drives its pin to 0.

With clear-to-send gating on, the transmitter starts a new character only while the synchronised active-low CTS input is low. The line is checked only between characters, so it never cuts a character short. With automatic RTS on, the RTS pin tells the far end whether the receive FIFO can take another byte, and the software RTS bit is ignored for the pin. Clearing an enable stops a path cleanly: a character already in flight finishes, and no new one starts. The FIFO never overwrites data. A byte that arrives while it is full is dropped and sets a sticky overrun flag.

Top module: `uart_flow_ctrl`

## Requirements
- R1: After reset, reg_rdata reads 0x0006: transmit enable (bit 1) and receive enable (bit 2) are 1, and every other bit is 0. rts_n and dtr_n are 1, txd is 1, rx_valid is 0 and rx_overrun is 0.
- R2: The control word uses bits 0 to 6: bit 0 is the global enable, bit 1 transmit enable, bit 2 receive enable, bit 3 DTR, bit 4 software RTS, bit 5 automatic RTS and bit 6 CTS gating. A write stores reg_wdata[6:0]. Bits 15 to 7 read as 0 and ignore writes.
- R3: When bits 0 and 1 are set and tx_valid and tx_ready are high on a clock edge, txd sends a frame: one low start bit, eight data bits LSB first and one high stop bit. Each bit lasts CLKS_PER_BIT clocks. txd idles high.
- R4: With CTS gating on, tx_ready is 0 and no frame starts while cts_n, after a two-flop synchroniser, is high. A rise of cts_n during a frame does not shorten that frame.
- R5: Clearing transmit enable during a frame lets the frame finish unchanged. After that, tx_ready stays 0 and txd stays high.
- R6: When bits 0 and 2 are set, a valid 8N1 frame on rxd is stored in the FIFO. rx_valid is 1 while the FIFO holds data. rx_data shows the oldest byte, and pulsing rx_pop for one cycle removes it. Bytes leave in arrival order.
- R7: Clearing receive enable during a reception still stores that byte. Frames that start later are not stored.
- R8: While automatic RTS is off, rts_n is the inverse of bit 4. dtr_n is always the inverse of bit 3.
- R9: While automatic RTS is on, rts_n is 0 when the FIFO has a free entry and 1 when it is full. Bit 4 has no effect on the pin but still reads back.
- R10: The FIFO holds FIFO_DEPTH entries (4 by default). A byte that arrives while the FIFO is full is dropped and sets rx_overrun. rx_overrun stays at 1 until reset, and the stored bytes are kept.
- R11: While the global enable is 0, no frame is sent (tx_ready is 0) and no received frame is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| reg_rdata | output | 16 | Control word read data |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Byte to transmit is present |
| tx_ready | output | 1 | Transmitter will take the byte on this edge |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rx_data | output | 8 | Oldest byte in the receive FIFO |
| rx_valid | output | 1 | Receive FIFO is not empty |
| rx_pop | input | 1 | Remove the oldest byte |
| rx_overrun | output | 1 | Sticky flag: a byte was dropped because the FIFO was full |

## Verification
The bench sweeps junk patterns through the upper control bits and all DTR/RTS combinations. It also sends several byte patterns both ways, among them all-zeros, all-ones and alternating bits. A design that checked CTS during a frame, or aborted on a disabled enable, would send a damaged character in the mid-frame CTS and transmit-disable tests. A receiver that obeyed its enable mid-frame would lose the byte in the mid-frame receive-disable test. The fill-to-overflow test catches a FIFO that overwrites its oldest byte, an RTS pin that ignores fullness or obeys the software bit in automatic mode, and an overrun flag that clears on pop.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
    localparam int REG_W  = 16;
    localparam int CTRL_W = 7;

    typedef struct packed {
        logic cts_flow;   // bit 6
        logic rts_flow;   // bit 5
        logic rts;        // bit 4
        logic dtr;        // bit 3
        logic rx_en;      // bit 2
        logic tx_en;      // bit 1
        logic uart_en;    // bit 0
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = 7'h06;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

    function automatic logic [9:0] make_frame(input logic [7:0] d);
        return {1'b1, d, 1'b0};
    endfunction
endpackage

// File: rtl/uart_fc_tx.sv
module uart_fc_tx #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] data,
    input  logic       valid,
    output logic       ready,
    output logic       busy,
    output logic       txd
);
    import uart_fc_pkg::*;
    localparam int CW = $clog2(CLKS_PER_BIT);

    logic [9:0]    sh_q;
    logic [3:0]    bit_q;
    logic [CW-1:0] cnt_q;
    logic          last;

    assign ready = !busy && go;
    assign txd   = busy ? sh_q[0] : 1'b1;
    assign last  = (cnt_q == '0) && (bit_q == 4'd9);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            sh_q  <= '1;
            bit_q <= '0;
            cnt_q <= '0;
        end else if (!busy) begin
            if (valid && go) begin
                busy  <= 1'b1;
                sh_q  <= make_frame(data);
                bit_q <= '0;
                cnt_q <= CW'(CLKS_PER_BIT - 1);
            end
        end else if (cnt_q == '0) begin
            cnt_q <= CW'(CLKS_PER_BIT - 1);
            sh_q  <= {1'b1, sh_q[9:1]};
            bit_q <= bit_q + 4'd1;
            if (last) busy <= 1'b0;
        end else begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // R5: once started, a frame runs to its stop bit regardless of go
    a_r5_frame_completes: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> busy);
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx #(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic       rxd,
    output logic       push,
    output logic [7:0] byte_out
);
    import uart_fc_pkg::*;
    localparam int CW   = $clog2(CLKS_PER_BIT);
    localparam int HALF = CLKS_PER_BIT / 2;

    logic [1:0]    sync_q;
    logic          rx_s;
    rx_state_t     st_q;
    logic [CW-1:0] cnt_q;
    logic [2:0]    bit_q;
    logic [7:0]    sr_q;

    assign rx_s     = sync_q[1];
    assign byte_out = sr_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], rxd};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RX_IDLE;
            cnt_q <= '0;
            bit_q <= '0;
            sr_q  <= '0;
            push  <= 1'b0;
        end else begin
            push <= 1'b0;
            case (st_q)
                RX_IDLE: if (go && !rx_s) begin
                    st_q  <= RX_START;
                    cnt_q <= CW'(HALF - 1);
                end
                RX_START: if (cnt_q == '0) begin
                    st_q  <= rx_s ? RX_IDLE : RX_DATA;
                    cnt_q <= CW'(CLKS_PER_BIT - 1);
                    bit_q <= '0;
                end else cnt_q <= cnt_q - CW'(1);
                RX_DATA: if (cnt_q == '0) begin
                    sr_q  <= {rx_s, sr_q[7:1]};
                    cnt_q <= CW'(CLKS_PER_BIT - 1);
                    bit_q <= bit_q + 3'd1;
                    if (bit_q == 3'd7) st_q <= RX_STOP;
                end else cnt_q <= cnt_q - CW'(1);
                RX_STOP: if (cnt_q == '0) begin
                    push <= 1'b1;
                    st_q <= RX_IDLE;
                end else cnt_q <= cnt_q - CW'(1);
                default: st_q <= RX_IDLE;
            endcase
        end
    end

    // R7: a reception in progress is not abandoned when go drops
    a_r7_rx_completes: assert property (@(posedge clk) disable iff (rst)
        (st_q == RX_DATA && !go) |=> (st_q != RX_IDLE));
endmodule

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  logic [7:0] wdata,
    input  logic       pop,
    output logic [7:0] rdata,
    output logic       not_empty,
    output logic       full,
    output logic       overrun
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem_q [DEPTH];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign full      = (cnt_q == CW'(DEPTH));
    assign not_empty = (cnt_q != '0);
    assign rdata     = mem_q[rp_q];
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;

    function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q    <= '0;
            rp_q    <= '0;
            cnt_q   <= '0;
            overrun <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (do_push) begin
                mem_q[wp_q] <= wdata;
                wp_q        <= inc(wp_q);
            end
            if (do_pop) rp_q <= inc(rp_q);
            if (push && full) overrun <= 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
            else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
        end
    end

    // R10: a push into a full FIFO is dropped and flagged
    a_r10_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (full && overrun));
    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl #(
    parameter int CLKS_PER_BIT = 16,
    parameter int FIFO_DEPTH   = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic [7:0]  tx_data,
    input  logic        tx_valid,
    output logic        tx_ready,
    output logic        txd,
    input  logic        rxd,
    input  logic        cts_n,
    output logic        rts_n,
    output logic        dtr_n,
    output logic [7:0]  rx_data,
    output logic        rx_valid,
    input  logic        rx_pop,
    output logic        rx_overrun
);
    import uart_fc_pkg::*;

    ctrl_t      ctrl_q;
    logic [1:0] cts_sync_q;
    logic       cts_ok, tx_go, rx_go, tx_busy;
    logic       rx_push, fifo_full;
    logic [7:0] rx_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= CTRL_RESET;
            cts_sync_q <= 2'b11;
        end else begin
            if (reg_we) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            cts_sync_q <= {cts_sync_q[0], cts_n};
        end
    end

    assign reg_rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
    assign cts_ok    = !cts_sync_q[1];
    assign tx_go     = ctrl_q.uart_en && ctrl_q.tx_en && (!ctrl_q.cts_flow || cts_ok);
    assign rx_go     = ctrl_q.uart_en && ctrl_q.rx_en;
    assign dtr_n     = !ctrl_q.dtr;
    assign rts_n     = ctrl_q.rts_flow ? fifo_full : !ctrl_q.rts;

    uart_fc_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst(rst), .go(tx_go), .data(tx_data), .valid(tx_valid),
        .ready(tx_ready), .busy(tx_busy), .txd(txd)
    );

    uart_fc_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk(clk), .rst(rst), .go(rx_go), .rxd(rxd),
        .push(rx_push), .byte_out(rx_byte)
    );

    uart_fc_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_byte), .pop(rx_pop),
        .rdata(rx_data), .not_empty(rx_valid), .full(fifo_full),
        .overrun(rx_overrun)
    );

    // R4: gated CTS keeps an idle transmitter idle
    a_r4_cts_gate: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.cts_flow && !cts_ok && !tx_busy) |=> !tx_busy);
    // R11: global enable off keeps an idle transmitter idle
    a_r11_global_off: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.uart_en && !tx_busy) |=> !tx_busy);
    // R8: DTR pin follows the last written bit 3, inverted
    a_r8_dtr_pin: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (dtr_n == !$past(reg_wdata[3])));
    // R9: a full FIFO deasserts RTS in automatic mode
    a_r9_rts_full: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.rts_flow && fifo_full) |-> rts_n);
endmodule

// File: tb/sim_uart_flow_ctrl.sv
module sim_uart_flow_ctrl;
    localparam int CPB = 8;

    logic        clk = 0, rst = 1;
    logic        reg_we = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic [7:0]  tx_data = 0, rx_data;
    logic        tx_valid = 0, tx_ready, txd;
    logic        rxd = 1, cts_n = 0, rts_n, dtr_n;
    logic        rx_valid, rx_pop = 0, rx_overrun;
    int errors = 0, checks = 0;

    always #10 clk = ~clk;

    uart_flow_ctrl #(.CLKS_PER_BIT(CPB), .FIFO_DEPTH(4)) u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .cts_n(cts_n),
        .rts_n(rts_n), .dtr_n(dtr_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_pop(rx_pop), .rx_overrun(rx_overrun)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] v);
        @(negedge clk); reg_we = 1; reg_wdata = v;
        @(negedge clk); reg_we = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pop();
        @(negedge clk); rx_pop = 1;
        @(negedge clk); rx_pop = 0;
    endtask

    // hand over a byte and decode the frame on txd at bit middles
    task automatic tx_frame(input logic [7:0] d, output logic [9:0] got);
        tx_data = d; tx_valid = 1;
        while (!tx_ready) @(negedge clk);
        @(posedge clk); #1 tx_valid = 0;
        repeat (4) @(negedge clk);
        got[0] = txd;
        for (int b = 1; b < 10; b++) begin
            repeat (CPB) @(negedge clk);
            got[b] = txd;
        end
        repeat (CPB) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] d);
        logic [9:0] f;
        f = {1'b1, d, 1'b0};
        for (int b = 0; b < 10; b++) begin
            @(negedge clk); rxd = f[b];
            repeat (CPB - 1) @(negedge clk);
        end
        repeat (2 * CPB) @(negedge clk);
    endtask

    // offer a byte for a while and require that nothing goes out
    task automatic tx_blocked(input string tag);
        bit seen = 0;
        tx_data = 8'h77; tx_valid = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tx_ready || !txd) seen = 1;
        end
        tx_valid = 0;
        check(!seen, tag, seen, 0);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [9:0] got;
        logic [7:0] pat [6];
        pat = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(reg_rdata == 16'h0006, "R1 rdata", reg_rdata, 16'h0006);
        check(rts_n && dtr_n && txd, "R1 pins", {rts_n, dtr_n, txd}, 3'b111);
        check(!rx_valid && !rx_overrun, "R1 fifo", {rx_valid, rx_overrun}, 0);

        // R2 sweep of junk through upper bits
        for (int i = 0; i < 32; i++) begin
            logic [15:0] v;
            v = 16'(i * 2053) ^ 16'hA5C3;
            wr(v);
            check(reg_rdata == (v & 16'h007F), "R2 readback", reg_rdata, v & 16'h007F);
        end

        // R8 all DTR / software RTS combinations
        for (int k = 0; k < 4; k++) begin
            wr(16'h0007 | 16'(k[0]) << 3 | 16'(k[1]) << 4);
            check(dtr_n == !k[0] && rts_n == !k[1], "R8 modem pins",
                  {rts_n, dtr_n}, {!k[1], !k[0]});
        end
        wr(16'h0007);

        // R3 transmit patterns
        foreach (pat[i]) begin
            tx_frame(pat[i], got);
            check(got == {1'b1, pat[i], 1'b0}, "R3 tx frame", got, {1'b1, pat[i], 1'b0});
        end

        // R4 CTS gating
        wr(16'h0047);
        cts_n = 1; repeat (4) @(negedge clk);
        tx_blocked("R4 cts high blocks");
        cts_n = 0; repeat (4) @(negedge clk);
        fork
            tx_frame(8'hC3, got);
            begin repeat (30) @(negedge clk); cts_n = 1; end
        join
        check(got == {1'b1, 8'hC3, 1'b0}, "R4 mid-frame cts", got, {1'b1, 8'hC3, 1'b0});
        check(!tx_ready, "R4 ready low after", tx_ready, 0);
        cts_n = 0;
        wr(16'h0007);

        // R5 transmit disable mid-frame
        fork
            tx_frame(8'h3C, got);
            begin repeat (30) @(negedge clk); wr(16'h0005); end
        join
        check(got == {1'b1, 8'h3C, 1'b0}, "R5 frame finished", got, {1'b1, 8'h3C, 1'b0});
        tx_blocked("R5 no new frame");
        wr(16'h0007);

        // R6 receive in order
        rx_frame(8'h96); rx_frame(8'h01); rx_frame(8'hF0);
        check(rx_valid && rx_data == 8'h96, "R6 first byte", rx_data, 8'h96);
        pop();
        check(rx_valid && rx_data == 8'h01, "R6 second byte", rx_data, 8'h01);
        pop();
        check(rx_valid && rx_data == 8'hF0, "R6 third byte", rx_data, 8'hF0);
        pop();
        check(!rx_valid, "R6 empty", rx_valid, 0);

        // R7 receive disable mid-frame
        fork
            rx_frame(8'h5E);
            begin repeat (40) @(negedge clk); wr(16'h0003); end
        join
        check(rx_valid && rx_data == 8'h5E, "R7 byte kept", rx_data, 8'h5E);
        pop();
        rx_frame(8'h11);
        check(!rx_valid, "R7 later frame dropped", rx_valid, 0);

        // R9 / R10 automatic RTS and overrun
        wr(16'h0027);
        check(!rts_n, "R9 rts low when empty", rts_n, 0);
        for (int i = 0; i < 4; i++) rx_frame(8'h20 + 8'(i));
        check(rts_n, "R9 rts high when full", rts_n, 1);
        wr(16'h0037);
        check(rts_n && reg_rdata == 16'h0037, "R9 sw bit ignored", {rts_n, reg_rdata}, {1'b1, 16'h0037});
        check(!rx_overrun, "R10 no overrun yet", rx_overrun, 0);
        rx_frame(8'hEE);
        check(rx_overrun, "R10 overrun set", rx_overrun, 1);
        for (int i = 0; i < 4; i++) begin
            check(rx_valid && rx_data == 8'h20 + 8'(i), "R10 data kept", rx_data, 8'h20 + 8'(i));
            pop();
            check(!rts_n, "R9 rts low after pop", rts_n, 0);
        end
        check(!rx_valid && rx_overrun, "R10 sticky and empty", {rx_valid, rx_overrun}, 2'b01);
        wr(16'h0027);
        check(!rts_n, "R9 sw bit 0 ignored", rts_n, 0);

        // R11 global enable off
        wr(16'h0006);
        tx_blocked("R11 tx off");
        rx_frame(8'h42);
        check(!rx_valid, "R11 rx off", rx_valid, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule